// File: doc/BRIEF.md
# Effective Address and Memory Address Select Unit

This combinational unit forms memory addresses for a 16-bit load/store processor. An adder sums a base value, taken from either the program counter or a general register, with an offset from the instruction word. The offset is zero or one of three signed immediate fields of different lengths, each sign-extended to the full data width. The sum is driven out as the effective address. It feeds branch, jump and call targets, and also the memory address path.

A second selector feeds the memory address path. It passes either the effective address or an 8-bit vector number taken from the instruction and zero-extended. The vector number serves trap-style table lookups. The controller drives all selects every cycle, and the outputs settle in the same cycle with no storage.

Top module: `ea_unit`

## Requirements
- R1: With `sel_base` = 0 the adder base is `pc`; with `sel_base` = 1 it is `ra`.
- R2: With `sel_off` = 2'b00 the offset is zero, so `ea_out` equals the selected base.
- R3: With `sel_off` = 2'b01 the offset is `ir[5:0]` read as a signed 6-bit value (all ones gives -1).
- R4: With `sel_off` = 2'b10 the offset is `ir[8:0]` read as a signed 9-bit value.
- R5: With `sel_off` = 2'b11 the offset is `ir[10:0]` read as a signed 11-bit value.
- R6: The sum wraps modulo 2^16 and has no carry output (0xFFFF + 1 gives 0x0000).
- R7: With `sel_mar` = 0, `addr_out` is `ir[7:0]` with bits 15..8 zero, whatever the base and offset selects are.
- R8: With `sel_mar` = 1, `addr_out` equals `ea_out`.
- R9: Instruction bits above the selected offset field, and the base input that is not selected, have no effect on `ea_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ir | input | 11 | Low instruction bits carrying the offset and vector fields |
| ra | input | 16 | Base register value |
| pc | input | 16 | Program counter value |
| sel_base | input | 1 | Base select: 0 program counter, 1 register |
| sel_off | input | 2 | Offset select: 00 zero, 01 6-bit, 10 9-bit, 11 11-bit |
| sel_mar | input | 1 | Address select: 0 vector number, 1 effective address |
| ea_out | output | 16 | Effective address (base plus offset, modulo 2^16) |
| addr_out | output | 16 | Memory address path output |

## Verification
The unit holds no state, so a wrong select decode or a sign extension taken from the wrong bit shows at `ea_out` in the cycle the inputs are applied. A fault in the address selector shows at `addr_out` in that same cycle. A sign bit taken from the wrong position only shows when that field's top bit is set. A fault in the upper bits of the vector path only shows when the base is nonzero. The sweep covers every instruction value under every select combination, with varied bases, so both conditions are reached.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int DATA_W  = 16,
  parameter int IR_W    = 11,
  parameter int SHORT_W = 6,
  parameter int MID_W   = 9,
  parameter int VEC_W   = 8
) (
  input  logic [IR_W-1:0]   ir,
  input  logic [DATA_W-1:0] ra,
  input  logic [DATA_W-1:0] pc,
  input  logic              sel_base,
  input  logic [1:0]        sel_off,
  input  logic              sel_mar,
  output logic [DATA_W-1:0] ea_out,
  output logic [DATA_W-1:0] addr_out
);

  logic [DATA_W-1:0] base, off_short, off_mid, off_long, offset, vec_zx;

  assign base      = sel_base ? ra : pc;
  assign off_short = {{(DATA_W-SHORT_W){ir[SHORT_W-1]}}, ir[SHORT_W-1:0]};
  assign off_mid   = {{(DATA_W-MID_W){ir[MID_W-1]}}, ir[MID_W-1:0]};
  assign off_long  = {{(DATA_W-IR_W){ir[IR_W-1]}}, ir};
  assign vec_zx    = {{(DATA_W-VEC_W){1'b0}}, ir[VEC_W-1:0]};

  always_comb begin
    unique case (sel_off)
      2'b00:   offset = '0;
      2'b01:   offset = off_short;
      2'b10:   offset = off_mid;
      default: offset = off_long;
    endcase
  end

  assign ea_out   = base + offset;
  assign addr_out = sel_mar ? ea_out : vec_zx;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int DATA_W = 16,
  parameter int IR_W   = 11
) (
  input logic [IR_W-1:0]   ir,
  input logic [DATA_W-1:0] ra,
  input logic [DATA_W-1:0] pc,
  input logic              sel_base,
  input logic [1:0]        sel_off,
  input logic              sel_mar,
  input logic [DATA_W-1:0] ea_out,
  input logic [DATA_W-1:0] addr_out
);

  logic [DATA_W-1:0] from_pc, from_ra;

  always_comb begin
    from_pc = ea_out - pc;
    from_ra = ea_out - ra;
    a_r2_zero_offset: assert (sel_off != 2'b00 || ea_out == (sel_base ? ra : pc))
      else $error("R2 zero offset mismatch");
    a_r1_pc_base: assert (sel_base || sel_off != 2'b01 ||
                          from_pc == {{(DATA_W-6){ir[5]}}, ir[5:0]})
      else $error("R1/R3 pc-relative short offset mismatch");
    a_r3_short_offset: assert (!sel_base || sel_off != 2'b01 ||
                               from_ra == {{(DATA_W-6){ir[5]}}, ir[5:0]})
      else $error("R3 register short offset mismatch");
    a_r4_mid_offset: assert (sel_base || sel_off != 2'b10 ||
                             from_pc == {{(DATA_W-9){ir[8]}}, ir[8:0]})
      else $error("R4 mid offset mismatch");
    a_r5_long_offset: assert (sel_base || sel_off != 2'b11 ||
                              from_pc == {{(DATA_W-IR_W){ir[IR_W-1]}}, ir})
      else $error("R5 long offset mismatch");
    a_r7_vector_path: assert (sel_mar || (addr_out[DATA_W-1:8] == '0 && addr_out[7:0] == ir[7:0]))
      else $error("R7 vector path mismatch");
    a_r8_ea_path: assert (!sel_mar || addr_out == ea_out)
      else $error("R8 address path mismatch");
  end

endmodule

bind ea_unit ea_unit_chk #(.DATA_W(DATA_W), .IR_W(IR_W)) u_chk (
  .ir(ir), .ra(ra), .pc(pc), .sel_base(sel_base), .sel_off(sel_off),
  .sel_mar(sel_mar), .ea_out(ea_out), .addr_out(addr_out)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [10:0] ir;
  logic [15:0] ra, pc, ea_out, addr_out;
  logic        sel_base, sel_mar;
  logic [1:0]  sel_off;

  int vectors = 0;
  int errors  = 0;
  int seed    = 12345;

  ea_unit u_ea_unit (
    .ir(ir), .ra(ra), .pc(pc), .sel_base(sel_base), .sel_off(sel_off),
    .sel_mar(sel_mar), .ea_out(ea_out), .addr_out(addr_out)
  );

  function automatic int sx(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic int next_rand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) & 16'hffff;
  endfunction

  task automatic apply(input int i_ir, input int i_ra, input int i_pc,
                       input int sb, input int so, input int sm, input string req);
    int b, off, exp_ea, exp_addr;
    @(posedge clk);
    ir = 11'(i_ir); ra = 16'(i_ra); pc = 16'(i_pc);
    sel_base = 1'(sb); sel_off = 2'(so); sel_mar = 1'(sm);
    b = sb ? (i_ra & 16'hffff) : (i_pc & 16'hffff);
    case (so)
      0: off = 0;
      1: off = sx(i_ir & 63, 6);
      2: off = sx(i_ir & 511, 9);
      default: off = sx(i_ir & 2047, 11);
    endcase
    exp_ea   = ((b + off) % 65536 + 65536) % 65536;
    exp_addr = sm ? exp_ea : (i_ir & 255);
    @(negedge clk);
    vectors++;
    if (int'(ea_out) != exp_ea || int'(addr_out) != exp_addr) begin
      errors++;
      $display("FAIL %s: ir=%h sb=%0d so=%0d sm=%0d ea=%h addr=%h expected ea=%h addr=%h",
               req, i_ir, sb, so, sm, ea_out, addr_out, exp_ea[15:0], exp_addr[15:0]);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    ir = '0; ra = '0; pc = '0; sel_base = 0; sel_off = 0; sel_mar = 0;
    // R7: initial vector path output with all-zero inputs
    apply(0, 0, 0, 0, 0, 0, "R7");
    // R3, R4, R5: all-ones fields give -1 at each width
    apply(11'h03f, 0, 16'h1000, 0, 1, 1, "R3");
    apply(11'h1ff, 0, 16'h1000, 0, 2, 1, "R4");
    apply(11'h7ff, 0, 16'h1000, 0, 3, 1, "R5");
    // R3, R4, R5: most negative value at each width, register base
    apply(11'h020, 16'h8000, 0, 1, 1, 1, "R3");
    apply(11'h100, 16'h8000, 0, 1, 2, 1, "R4");
    apply(11'h400, 16'h8000, 0, 1, 3, 1, "R5");
    // R9: bits above the short field set but short field positive
    apply(11'h7c5, 16'h0100, 16'h0200, 1, 1, 1, "R9");
    // R6: wrap at top of address space, and below zero
    apply(11'h001, 0, 16'hffff, 0, 1, 1, "R6");
    apply(11'h7ff, 0, 16'h0000, 0, 3, 1, "R6");
    // R2, R1: zero offset passes base through
    apply(11'h7ff, 16'hbeef, 16'h1234, 0, 0, 1, "R1");
    apply(11'h7ff, 16'hbeef, 16'h1234, 1, 0, 1, "R2");
    // R7: vector path ignores a large base
    apply(11'h7ab, 16'hffff, 16'hffff, 1, 3, 0, "R7");
    // R8: sweep of every instruction value under every select combination
    for (int v = 0; v < 2048; v++) begin
      for (int k = 0; k < 16; k++) begin
        int r, p;
        r = next_rand();
        p = next_rand();
        apply(v, r, p, k & 1, (k >> 1) & 3, (k >> 3) & 1,
              ((k >> 3) & 1) != 0 ? "R8" : "R7");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule